// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences one DMA channel. Software uses a small register port to program a source address, a destination address, a transfer count and a control word. It then sets the run bit. From that point the channel requests the bus and waits for a grant. For each transfer it issues a one-cycle read strobe at the source address, then a one-cycle write strobe at the destination address. After each group of transfers it drives an external acknowledge for a programmed number of cycles.

Each side of the transfer has its own address direction: the address can count up, count down or stay fixed. The size of each address step follows the transfer width. In burst mode one bus grant covers up to four transfers. The channel shows a busy status while a run is active. When a run completes normally, it can set a sticky interrupt flag. If software clears the run bit during a run, the run stops and no interrupt is raised.

Top module: `dma_chan_seq`

## Requirements
- R1: The width field is CTRL[3:2]. Code 00 steps the address by 1, code 01 by 2, and code 10 by 4. The reserved code 11 also steps by 4.
- R2: The source direction field is CTRL[5:4] and the destination direction field is CTRL[7:6]. Each field is decoded on its own: 00 counts up, 01 counts down, and 10 or 11 holds the address fixed. The address moves once per transfer, after the transfer's strobe.
- R3: A run performs exactly COUNT transfers. Each transfer is a one-cycle `rd_stb` at the current source address, followed in the next cycle by a one-cycle `wr_stb` at the current destination address. Both strobes occur only while `bus_req` is high.
- R4: After each group of transfers `ext_ack` is high for N+1 consecutive cycles, where N is CTRL[12:9]. No strobe is issued while `ext_ack` is high.
- R5: STATUS bit 0 (busy) reads 1 from the cycle after the start write until the last acknowledge of the run has ended. When the run ends, CTRL bit 0 (run) reads 0. A start with COUNT equal to 0 leaves the channel idle.
- R6: If CTRL[8] is 1, normal completion sets a sticky flag, shown at `irq` and as STATUS bit 1. Writing 1 to STATUS bit 1 clears the flag.
- R7: Writing CTRL with bit 0 at 0 during a run stops the run in the next cycle. It drops `bus_req` and `ext_ack`, clears busy, and leaves `irq` unchanged.
- R8: When CTRL[1] (burst) is 1, one grant covers up to four transfers and a single acknowledge follows each group. A run of C transfers therefore gives ceil(C/4) acknowledges, against C acknowledges without burst.
- R9: A start with burst set and either direction at 01 is rejected. The channel stays idle, no bus request is made, and CTRL bit 0 reads 0.
- R10: Register offsets are 0 CTRL, 1 SRC, 2 DST, 3 COUNT and 4 STATUS. Writes to SRC, DST and COUNT during a run are ignored. Reading SRC, DST or COUNT returns the current address or the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| bus_req | output | 1 | Bus request, held through the read and write beats |
| bus_gnt | input | 1 | Bus grant |
| rd_stb | output | 1 | Single-cycle read strobe |
| rd_addr | output | AW | Current source address |
| wr_stb | output | 1 | Single-cycle write strobe |
| wr_addr | output | AW | Current destination address |
| xfer_size | output | 2 | Transfer width code |
| ext_ack | output | 1 | External acknowledge pulse |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench attacks the edges of the address arithmetic. These are a decrementing source, a fixed side paired with a stepping side, the reserved width and direction codes, and a burst run whose count is not a multiple of four. A design with a wrong step table or wrong direction decode would put a wrong address on some strobe. A design with a wrong burst grouping would give the wrong number of acknowledge pulses. The bench measures the length of every acknowledge pulse, including the 16-cycle maximum, which catches an off-by-one in the timer. It then aborts a run with the interrupt enabled and makes a start with burst and decrement set. A design that raised the flag on abort, or began that start, would show a set `irq`, a busy status or a bus request. Mid-run writes to SRC and COUNT must leave the final address unchanged, so a design that let them through would end at the wrong address.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_ACK  = 3'd4
  } seq_state_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic [3:0] ack_len;
    logic       irq_en;
    logic [1:0] ddir;
    logic [1:0] sdir;
    logic [1:0] width;
    logic       burst;
    logic       run;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

  localparam logic [2:0] OFF_CTRL   = 3'd0;
  localparam logic [2:0] OFF_SRC    = 3'd1;
  localparam logic [2:0] OFF_DST    = 3'd2;
  localparam logic [2:0] OFF_COUNT  = 3'd3;
  localparam logic [2:0] OFF_STATUS = 3'd4;

  function automatic logic [2:0] step_bytes(input logic [1:0] width);
    case (width)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic dir_is_down(input logic [1:0] dir);
    dir_is_down = (dir == 2'b01);
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [1:0]    dir,
  input  logic [1:0]    width,
  output logic [AW-1:0] addr
);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] cur,
                                              input logic [1:0] d,
                                              input logic [1:0] w);
    logic [AW-1:0] delta;
    delta = AW'(step_bytes(w));
    case (d)
      2'b00:   next_addr = cur + delta;
      2'b01:   next_addr = cur - delta;
      default: next_addr = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= next_addr(addr, dir, width);
  end

endmodule

// File: rtl/dma_ack_timer.sv
module dma_ack_timer #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr,
  input  logic [LW-1:0] len,
  output logic          active,
  output logic          last
);

  logic [LW-1:0] tick_q;

  assign last = active && (tick_q == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick_q <= '0;
    end else if (clr) begin
      active <= 1'b0;
      tick_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      tick_q <= '0;
    end else if (last) begin
      active <= 1'b0;
    end else if (active) begin
      tick_q <= tick_q + 1'b1;
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           rd_stb,
  output logic [AW-1:0]  rd_addr,
  output logic           wr_stb,
  output logic [AW-1:0]  wr_addr,
  output logic [1:0]     xfer_size,
  output logic           ext_ack,
  output logic           irq
);

  localparam int BEATS_PER_GRANT = 4;
  localparam int BW = $clog2(BEATS_PER_GRANT);

  seq_state_e     state_q, state_d;
  ctrl_t          ctrl_q, ctrl_w;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  beat_q;
  logic           irq_q;

  // named internal events
  logic ctrl_wr, stat_wr, idle, busy;
  logic start_evt, reject_evt, abort_evt, beat_done, group_end, done_evt;
  logic ack_active, ack_last, start_legal;

  assign idle    = (state_q == ST_IDLE);
  assign busy    = !idle;
  assign ctrl_wr = reg_we && (reg_addr == RAW'(OFF_CTRL));
  assign stat_wr = reg_we && (reg_addr == RAW'(OFF_STATUS));
  assign ctrl_w  = ctrl_t'(reg_wdata[CTRL_BITS-1:0]);

  assign start_legal = (cnt_q != '0) &&
                       !(ctrl_w.burst && (dir_is_down(ctrl_w.sdir) || dir_is_down(ctrl_w.ddir)));
  assign start_evt   = ctrl_wr && ctrl_w.run && idle && start_legal;
  assign reject_evt  = ctrl_wr && ctrl_w.run && idle && !start_legal;
  assign abort_evt   = ctrl_wr && !ctrl_w.run && busy;
  assign beat_done   = (state_q == ST_WR);
  assign group_end   = beat_done &&
                       ((cnt_q == CW'(1)) || !ctrl_q.burst || (beat_q == BW'(BEATS_PER_GRANT - 1)));
  assign done_evt    = (state_q == ST_ACK) && ack_last && (cnt_q == '0) && !abort_evt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_evt) state_d = ST_REQ;
      ST_REQ:  if (bus_gnt) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = group_end ? ST_ACK : ST_RD;
      ST_ACK:  if (ack_last) state_d = (cnt_q == '0) ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
    if (abort_evt) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      cnt_q   <= '0;
      beat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;

      if (ctrl_wr && idle) begin
        ctrl_q     <= ctrl_w;
        ctrl_q.run <= start_evt;
      end else if (abort_evt || done_evt) begin
        ctrl_q.run <= 1'b0;
      end

      if (idle && reg_we && (reg_addr == RAW'(OFF_COUNT)))
        cnt_q <= reg_wdata[CW-1:0];
      else if (beat_done && !abort_evt)
        cnt_q <= cnt_q - 1'b1;

      if (state_q == ST_REQ)
        beat_q <= '0;
      else if (beat_done)
        beat_q <= beat_q + 1'b1;

      if (done_evt && ctrl_q.irq_en)
        irq_q <= 1'b1;
      else if (stat_wr && reg_wdata[1])
        irq_q <= 1'b0;
    end
  end

  dma_addr_unit #(.AW(AW)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idle && reg_we && (reg_addr == RAW'(OFF_SRC))),
    .load_val (reg_wdata[AW-1:0]),
    .step     (beat_done && !abort_evt),
    .dir      (ctrl_q.sdir),
    .width    (ctrl_q.width),
    .addr     (rd_addr)
  );

  dma_addr_unit #(.AW(AW)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idle && reg_we && (reg_addr == RAW'(OFF_DST))),
    .load_val (reg_wdata[AW-1:0]),
    .step     (beat_done && !abort_evt),
    .dir      (ctrl_q.ddir),
    .width    (ctrl_q.width),
    .addr     (wr_addr)
  );

  dma_ack_timer #(.LW(4)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (group_end && !abort_evt),
    .clr    (abort_evt),
    .len    (ctrl_q.ack_len),
    .active (ack_active),
    .last   (ack_last)
  );

  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
  assign rd_stb    = (state_q == ST_RD);
  assign wr_stb    = (state_q == ST_WR);
  assign xfer_size = ctrl_q.width;
  assign ext_ack   = ack_active;
  assign irq       = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RAW'(OFF_CTRL):   reg_rdata = DW'(ctrl_q);
      RAW'(OFF_SRC):    reg_rdata = DW'(rd_addr);
      RAW'(OFF_DST):    reg_rdata = DW'(wr_addr);
      RAW'(OFF_COUNT):  reg_rdata = DW'(cnt_q);
      RAW'(OFF_STATUS): reg_rdata = DW'({irq_q, busy});
      default:          reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          ext_ack,
  input logic          irq,
  input logic          busy,
  input logic          start_evt,
  input logic          reject_evt,
  input logic          abort_evt,
  input logic          done_evt,
  input logic          irq_en,
  input logic [1:0]    sdir,
  input logic [AW-1:0] rd_addr
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R3
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !abort_evt |=> wr_stb); // R3
  AST_STROBE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> bus_req); // R3
  AST_QUIET_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> !(rd_stb || wr_stb)); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy); // R5
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && irq_en |=> irq); // R6
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !bus_req && !ext_ack && $stable(irq))); // R7
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (!busy && !bus_req)); // R9
  AST_FIXED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && sdir[1] && !abort_evt |=> $stable(rd_addr)); // R2

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .ext_ack    (ext_ack),
  .irq        (irq),
  .busy       (busy),
  .start_evt  (start_evt),
  .reject_evt (reject_evt),
  .abort_evt  (abort_evt),
  .done_evt   (done_evt),
  .irq_en     (ctrl_q.irq_en),
  .sdir       (ctrl_q.sdir),
  .rd_addr    (rd_addr)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic        rd_stb, wr_stb, ext_ack, irq;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  xfer_size;

  always #10 clk = ~clk;

  dma_chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .xfer_size(xfer_size), .ext_ack(ext_ack), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  w, sd, dd;
    logic        b, ie;
    logic [3:0]  ack;
    logic [7:0]  cnt;
    logic [31:0] es, ed;
    logic [7:0]  np;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd0,  8'd3, 32'h103, 32'h803, 8'd3},
    '{2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 4'd3,  8'd4, 32'h0F8, 32'h800, 8'd4},
    '{2'd2, 2'd2, 2'd1, 1'b0, 1'b1, 4'd15, 8'd2, 32'h100, 32'h7F8, 8'd2},
    '{2'd2, 2'd0, 2'd0, 1'b1, 1'b1, 4'd1,  8'd6, 32'h118, 32'h818, 8'd2},
    '{2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd0,  8'd2, 32'h100, 32'h802, 8'd2},
    '{2'd1, 2'd2, 2'd0, 1'b1, 1'b1, 4'd2,  8'd5, 32'h100, 32'h80A, 8'd2},
    '{2'd3, 2'd0, 2'd1, 1'b0, 1'b1, 4'd0,  8'd1, 32'h104, 32'h7FC, 8'd1}
  };

  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor state
  bit          mon_on = 0;
  logic [1:0]  cur_w, cur_sd, cur_dd;
  logic [3:0]  cur_ack;
  logic [31:0] exp_src, exp_dst;
  int          writes = 0, pulses = 0, ack_run = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bstep(input logic [31:0] a, input logic [1:0] d, input logic [1:0] w);
    int inc;
    inc = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    if (d == 2'd0) return a + inc;
    if (d == 2'd1) return a - inc;
    return a;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cword(input logic [1:0] w, sd, dd, input logic b, ie, input logic [3:0] ack, input logic run);
    return {19'd0, ack, ie, dd, sd, w, b, run};
  endfunction

  task automatic wait_idle(output bit seen_busy);
    logic [31:0] st;
    seen_busy = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, st);
      if (st[0]) seen_busy = 1;
      else break;
    end
  endtask

  // grant follows request
  initial forever @(negedge clk) bus_gnt = bus_req;

  // port monitor
  initial forever @(negedge clk) begin
    if (ext_ack) begin
      ack_run++;
      if (rd_stb || wr_stb) chk(0, "R4 strobe during ack", {30'd0, rd_stb, wr_stb}, 0);
    end else if (ack_run != 0) begin
      pulses++;
      if (mon_on) chk(ack_run == int'(cur_ack) + 1, "R4 ack length", ack_run, cur_ack + 1);
      ack_run = 0;
    end
    if (mon_on && rd_stb) begin
      chk(rd_addr == exp_src, "R1/R2 read address", rd_addr, exp_src);
      chk(bus_req, "R3 read under request", bus_req, 1);
      exp_src = bstep(exp_src, cur_sd, cur_w);
    end
    if (mon_on && wr_stb) begin
      chk(wr_addr == exp_dst, "R1/R2 write address", wr_addr, exp_dst);
      exp_dst = bstep(exp_dst, cur_dd, cur_w);
      writes++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit sb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R5
    rd(3'd4, v); chk(v == 0, "R5 reset status", v, 0);
    chk(!bus_req && !ext_ack && !irq && !rd_stb && !wr_stb, "R5 reset outputs",
        {bus_req, ext_ack, irq, rd_stb, wr_stb}, 0);

    // vector table walk
    for (int k = 0; k < NV; k++) begin
      vec_t t;
      t = VEC[k];
      wr(3'd1, 32'h100); wr(3'd2, 32'h800); wr(3'd3, {24'd0, t.cnt});
      cur_w = t.w; cur_sd = t.sd; cur_dd = t.dd; cur_ack = t.ack;
      exp_src = 32'h100; exp_dst = 32'h800; writes = 0; pulses = 0; mon_on = 1;
      wr(3'd0, cword(t.w, t.sd, t.dd, t.b, t.ie, t.ack, 1'b1));
      wait_idle(sb);
      repeat (2) @(negedge clk);
      mon_on = 0;
      chk(sb, "R5 busy seen during run", sb, 1);
      chk(writes == int'(t.cnt), "R3 transfer count", writes, t.cnt);
      chk(pulses == int'(t.np), "R8 ack pulses per run", pulses, t.np);
      rd(3'd1, v); chk(v == t.es, "R1 final source", v, t.es);
      rd(3'd2, v); chk(v == t.ed, "R2 final destination", v, t.ed);
      chk(irq == t.ie, "R6 irq after completion", irq, t.ie);
      rd(3'd0, v); chk(v[0] == 1'b0, "R5 run bit cleared", v[0], 0);
      wr(3'd4, 32'h2);
      chk(irq == 1'b0, "R6 irq write-one clear", irq, 0);
    end

    // R10 writes ignored mid-run
    wr(3'd1, 32'h100); wr(3'd2, 32'h800); wr(3'd3, 32'd2);
    cur_w = 0; cur_sd = 0; cur_dd = 0; cur_ack = 4'd7;
    exp_src = 32'h100; exp_dst = 32'h800; writes = 0; mon_on = 1;
    wr(3'd0, cword(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd7, 1'b1));
    wr(3'd1, 32'h5000); wr(3'd3, 32'd50);
    wait_idle(sb);
    repeat (2) @(negedge clk);
    mon_on = 0;
    rd(3'd1, v); chk(v == 32'h102, "R10 source write ignored", v, 32'h102);
    rd(3'd3, v); chk(v == 0, "R10 count write ignored", v, 0);

    // R7 abort
    wr(3'd1, 32'h100); wr(3'd2, 32'h800); wr(3'd3, 32'd20);
    wr(3'd0, cword(2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 4'd3, 1'b1));
    repeat (10) @(negedge clk);
    wr(3'd0, cword(2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 4'd3, 1'b0));
    chk(!bus_req && !ext_ack, "R7 abort drops request", {bus_req, ext_ack}, 0);
    rd(3'd4, v); chk(v == 0, "R7 abort status", v, 0);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R7 no irq after abort", irq, 0);

    // R9 burst with decrement rejected
    wr(3'd3, 32'd4);
    wr(3'd0, cword(2'd2, 2'd1, 2'd0, 1'b1, 1'b1, 4'd0, 1'b1));
    rd(3'd4, v); chk(v[0] == 0, "R9 rejected start not busy", v, 0);
    rd(3'd0, v); chk(v[0] == 0, "R9 run bit reads 0", v[0], 0);
    sb = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_req) sb = 1;
    end
    chk(!sb, "R9 no bus request", sb, 0);

    // R5 zero count start
    wr(3'd3, 32'd0);
    wr(3'd0, cword(2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd0, 1'b1));
    rd(3'd4, v); chk(v == 0, "R5 zero count stays idle", v, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule